// File: doc/BRIEF.md
# Unified Integer and Fractional Multiplier

This block multiplies two 16-bit operands and returns a 32-bit result with an overflow flag. Each operand has its own sign-mode bit, so it can be read as two's complement or as a plain binary magnitude. A third mode bit selects how the product is read. In integer mode the result is the ordinary product. In fractional (Q-format) mode the result is the product shifted left by one place, which removes the duplicate sign bit that a signed-by-signed fractional product carries.

Both operands are widened by one bit. That bit is a copy of bit 15 for a signed operand and zero for an unsigned one. One signed multiplier of the widened width then covers every sign pairing. The only fractional product that cannot be represented is minus one times minus one. The block detects it, clamps the result to the largest positive value and raises the overflow flag.

By default the result and flag are registered, so the output shows the inputs that were present at the previous rising clock edge.

Top module: `fxm_unified_mul`

## Requirements
- R1: With mode bits a_signed_i=0, b_signed_i=0 (0 means unsigned) and frac_i=0 (0 means integer), prod_o is the full 32-bit unsigned product of the two operands.
- R2: With a_signed_i=1, b_signed_i=1 (1 means signed) and frac_i=0, prod_o is the 32-bit two's complement product of the two signed operands.
- R3: Each operand's sign mode acts on its own. With exactly one operand signed and frac_i=0, prod_o is the two's complement product of the signed operand and the unsigned magnitude of the other operand.
- R4: With frac_i=1 (1 means fractional), outside the case in R5, prod_o equals bits 30:0 of the 34-bit widened product followed by a 0 in bit 0.
- R5: With frac_i=1, both operands signed and both equal to 0x8000, prod_o is 0x7FFFFFFF and ovf_o is 1.
- R6: ovf_o is 0 for every other input and mode combination. This includes 0x8000 times 0x8000 in integer mode and in fractional mode when either operand is unsigned.
- R7: While rst_n is low, prod_o and ovf_o are 0. After reset, prod_o and ovf_o show the inputs sampled at the previous rising edge of clk and do not change between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| a_signed_i | input | 1 | First operand sign mode: 1 signed, 0 unsigned |
| b_signed_i | input | 1 | Second operand sign mode: 1 signed, 0 unsigned |
| frac_i | input | 1 | Product mode: 1 fractional, 0 integer |
| prod_o | output | 32 | Product, registered |
| ovf_o | output | 1 | Fractional saturation occurred, registered |

## Verification
Two things act on the same operation: the fractional left shift and the saturation clamp. Both respond to 0x8000 times 0x8000, and the clamp must take priority over the shift. The bench applies that operand pair under all eight mode combinations, one after another. It expects a clamp only in the fractional signed-by-signed case, and in every other case it expects the shifted or unshifted product with the flag low. Random operands, mixed with the values 0, 0x7FFF, 0x8000 and 0xFFFF, cover the points around the corner case.

// File: rtl/fxm_pkg.sv
package fxm_pkg;
   typedef enum logic {
      OPD_UNSIGNED = 1'b0,
      OPD_SIGNED   = 1'b1
   } opd_mode_e;

   typedef enum logic {
      PROD_INTEGER    = 1'b0,
      PROD_FRACTIONAL = 1'b1
   } prod_mode_e;
endpackage

// File: rtl/fxm_widen.sv
module fxm_widen #(
   parameter int W = 16
) (
   input  logic [W-1:0] opd_i,
   input  logic         sgn_i,
   output logic [W:0]   ext_o
);
   generate
      if (W < 2) begin : g_bad_width
         $error("fxm_widen: W must be at least 2");
      end
   endgenerate

   always_comb begin
      ext_o = {(sgn_i == fxm_pkg::OPD_SIGNED) ? opd_i[W-1] : 1'b0, opd_i};
   end
endmodule

// File: rtl/fxm_core.sv
module fxm_core #(
   parameter int W = 16,
   localparam int EW = W + 1,
   localparam int PW = 2 * EW
) (
   input  logic [EW-1:0] x_i,
   input  logic [EW-1:0] y_i,
   output logic [PW-1:0] p_o
);
   logic signed [EW-1:0] xs;
   logic signed [EW-1:0] ys;
   logic signed [PW-1:0] ps;

   always_comb begin
      xs  = signed'(x_i);
      ys  = signed'(y_i);
      ps  = PW'(xs) * PW'(ys);
      p_o = unsigned'(ps);
   end
endmodule

// File: rtl/fxm_format.sv
module fxm_format #(
   parameter int W = 16,
   localparam int PW = 2 * (W + 1),
   localparam int OW = 2 * W
) (
   input  logic [PW-1:0] p_i,
   input  logic          frac_i,
   input  logic          a_sgn_i,
   input  logic          b_sgn_i,
   output logic [OW-1:0] res_o,
   output logic          ovf_o
);
   localparam logic [PW-1:0] CORNER = PW'(1) << (OW - 2);
   localparam logic [OW-1:0] MAXPOS = {1'b0, {(OW-1){1'b1}}};

   logic hit;

   always_comb begin
      hit   = (p_i == CORNER);
      ovf_o = frac_i & a_sgn_i & b_sgn_i & hit;
      if (ovf_o)
         res_o = MAXPOS;
      else if (frac_i == fxm_pkg::PROD_FRACTIONAL)
         res_o = {p_i[OW-2:0], 1'b0};
      else
         res_o = p_i[OW-1:0];
   end
endmodule

// File: rtl/fxm_unified_mul.sv
module fxm_unified_mul #(
   parameter int W       = 16,
   parameter bit OUT_REG = 1'b1,
   localparam int EW = W + 1,
   localparam int PW = 2 * EW,
   localparam int OW = 2 * W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [W-1:0]  a_i,
   input  logic [W-1:0]  b_i,
   input  logic          a_signed_i,
   input  logic          b_signed_i,
   input  logic          frac_i,
   output logic [OW-1:0] prod_o,
   output logic          ovf_o
);
   localparam logic [W-1:0]  MINNEG = {1'b1, {(W-1){1'b0}}};
   localparam logic [OW-1:0] MAXPOS = {1'b0, {(OW-1){1'b1}}};

   logic [EW-1:0] a_ext;
   logic [EW-1:0] b_ext;
   logic [PW-1:0] p_full;
   logic [OW-1:0] res_c;
   logic          ovf_c;

   fxm_widen #(.W(W)) u_wa (.opd_i(a_i), .sgn_i(a_signed_i), .ext_o(a_ext));
   fxm_widen #(.W(W)) u_wb (.opd_i(b_i), .sgn_i(b_signed_i), .ext_o(b_ext));

   fxm_core #(.W(W)) u_core (.x_i(a_ext), .y_i(b_ext), .p_o(p_full));

   fxm_format #(.W(W)) u_fmt (
      .p_i    (p_full),
      .frac_i (frac_i),
      .a_sgn_i(a_signed_i),
      .b_sgn_i(b_signed_i),
      .res_o  (res_c),
      .ovf_o  (ovf_c)
   );

   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               prod_o <= '0;
               ovf_o  <= 1'b0;
            end else begin
               prod_o <= res_c;
               ovf_o  <= ovf_c;
            end
         end

         // R5
         sat_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ovf_o |-> (prod_o == MAXPOS));

         // R6
         no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && ovf_o) |-> $past(frac_i && a_signed_i && b_signed_i
                                             && (a_i == MINNEG) && (b_i == MINNEG)));

         // R4
         frac_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(frac_i) && !ovf_o) |-> !prod_o[0]);

         // R1
         uu_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(!frac_i && !a_signed_i && !b_signed_i))
               |-> (prod_o == $past(OW'(a_i) * OW'(b_i))));

         // R2
         ss_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(!frac_i && a_signed_i && b_signed_i))
               |-> (prod_o == $past(OW'(signed'(a_i)) * OW'(signed'(b_i)))));
      end else begin : g_comb
         always_comb begin
            prod_o = rst_n ? res_c : '0;
            ovf_o  = rst_n ? ovf_c : 1'b0;
         end
      end
   endgenerate
endmodule

// File: tb/tb_fxm_unified_mul.sv
module tb_fxm_unified_mul;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] a = '0;
   logic [15:0] b = '0;
   logic        sa = 1'b0;
   logic        sb = 1'b0;
   logic        fr = 1'b0;
   logic [31:0] prod;
   logic        ovf;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   fxm_unified_mul dut (
      .clk(clk), .rst_n(rst_n), .a_i(a), .b_i(b),
      .a_signed_i(sa), .b_signed_i(sb), .frac_i(fr),
      .prod_o(prod), .ovf_o(ovf)
   );

   function automatic logic [32:0] model(input logic [15:0] x, input logic [15:0] y,
                                         input logic xs, input logic ys, input logic f);
      longint xv, yv, pv;
      logic [63:0] pb;
      xv = xs ? longint'($signed(x)) : longint'(x);
      yv = ys ? longint'($signed(y)) : longint'(y);
      pv = xv * yv;
      pb = pv;
      if (f && xs && ys && x == 16'h8000 && y == 16'h8000)
         return {1'b1, 32'h7FFF_FFFF};
      if (f)
         return {1'b0, pb[30:0], 1'b0};
      return {1'b0, pb[31:0]};
   endfunction

   task automatic check(input string req, input logic [31:0] ep, input logic eo);
      checks++;
      if (prod !== ep || ovf !== eo) begin
         errors++;
         $display("FAIL %s: a=%h b=%h sa=%0d sb=%0d fr=%0d got prod=%h ovf=%0d expected prod=%h ovf=%0d",
                  req, a, b, sa, sb, fr, prod, ovf, ep, eo);
      end
   endtask

   task automatic apply(input logic [15:0] x, input logic [15:0] y,
                        input logic xs, input logic ys, input logic f, input string req);
      logic [32:0] e;
      @(negedge clk);
      a = x; b = y; sa = xs; sb = ys; fr = f;
      e = model(x, y, xs, ys, f);
      @(negedge clk);
      check(req, e[31:0], e[32]);
   endtask

   function automatic string tag_of(input logic xs, input logic ys, input logic f);
      if (f) return "R4";
      if (!xs && !ys) return "R1";
      if (xs && ys) return "R2";
      return "R3";
   endfunction

   initial begin
      logic [15:0] edges [4];
      logic [32:0] e;
      logic [31:0] held;
      edges[0] = 16'h0000; edges[1] = 16'h7FFF; edges[2] = 16'h8000; edges[3] = 16'hFFFF;
      void'($urandom(32'd20240611));

      // R7: reset state
      a = 16'hFFFF; b = 16'hFFFF; sa = 1'b0; sb = 1'b0;
      repeat (3) @(negedge clk);
      check("R7", 32'h0, 1'b0);
      a = '0; b = '0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R7", 32'h0, 1'b0);

      // Directed known values
      apply(16'hFFFF, 16'hFFFF, 1'b0, 1'b0, 1'b0, "R1"); // 0xFFFE0001
      apply(16'hFFFF, 16'hFFFF, 1'b1, 1'b1, 1'b0, "R2"); // 1
      apply(16'hFFFF, 16'h0002, 1'b1, 1'b0, 1'b0, "R3"); // -2
      apply(16'h0002, 16'hFFFF, 1'b1, 1'b0, 1'b0, "R3"); // 0x1FFFE
      apply(16'h4000, 16'h4000, 1'b1, 1'b1, 1'b1, "R4"); // 0.5*0.5 -> 0x20000000

      // R5 and R6: corner operands under every mode
      for (int m = 0; m < 8; m++) begin
         apply(16'h8000, 16'h8000, m[0], m[1], m[2],
               (m == 7) ? "R5" : "R6");
      end
      apply(16'h8000, 16'h8000, 1'b1, 1'b1, 1'b1, "R5");
      apply(16'h8000, 16'h8001, 1'b1, 1'b1, 1'b1, "R6");
      apply(16'h8001, 16'h8000, 1'b1, 1'b1, 1'b1, "R6");

      // Edge operand grid
      for (int i = 0; i < 4; i++)
         for (int j = 0; j < 4; j++)
            for (int m = 0; m < 8; m++)
               apply(edges[i], edges[j], m[0], m[1], m[2], tag_of(m[0], m[1], m[2]));

      // R7: output holds between edges, updates one edge later
      @(negedge clk);
      a = 16'h0003; b = 16'h0005; sa = 1'b0; sb = 1'b0; fr = 1'b0;
      @(negedge clk);
      check("R7", 32'd15, 1'b0);
      held = prod;
      a = 16'h0007; b = 16'h0009;
      #5;
      check("R7", held, 1'b0);
      @(negedge clk);
      check("R7", 32'd63, 1'b0);

      // Random stimulus mixed with edge values
      for (int k = 0; k < 2000; k++) begin
         logic [15:0] x, y;
         logic [2:0]  md;
         x  = ($urandom % 5 == 0) ? edges[$urandom % 4] : 16'($urandom);
         y  = ($urandom % 5 == 0) ? edges[$urandom % 4] : 16'($urandom);
         md = 3'($urandom);
         apply(x, y, md[0], md[1], md[2], tag_of(md[0], md[1], md[2]));
      end

      // R7: reset clears outputs again
      apply(16'h8000, 16'h8000, 1'b1, 1'b1, 1'b1, "R5");
      #2 rst_n = 1'b0;
      #3;
      e = '0;
      check("R7", e[31:0], e[32]);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(20 * 200000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not finish, got timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule